// File: doc/BRIEF.md
# Configurable Output Cell Bank

This block sits between a programmable AND array and the eight bidirectional pins of a small array-logic device. Each of the eight cells takes a sum-of-products value and a direction term from the array. The cell applies its own polarity choice to that value. It then either registers the value or drives it straight through, and it controls the pin's output enable. The pin model is split into drive, enable and an externally applied value. Each cell also returns a feedback bit to the array: the register state for registered cells, and the pin value for all other cells.

A pair of mode bits per cell selects one of four behaviours. A single global configuration bit is derived from the cell modes. While any cell is registered, pin 1 acts as the register clock and pin 11 as the shared enable of all registered outputs. Otherwise both pins feed the array as plain inputs. The registers have a power-up clear, an asynchronous clear from a global term, a synchronous preset from a second global term, and a synchronous preload path used for test.

Top module: `omc_bank`

## Requirements
- R1: The mode of each cell is decoded from {ac1, ac2}. 2'b11 selects registered, 2'b00 bidirectional, 2'b01 fixed input and 2'b10 fixed output. The all-zero setting is bidirectional.
- R2: The polarity bit pol=0 drives the inverse of the cell's sum, and pol=1 drives the sum unchanged. This holds for both the registered and the combinational path.
- R3: In bidirectional mode the pin enable equals the cell's direction term, asynchronously, and the drive is the polarity-adjusted sum.
- R4: In fixed-input mode the pin enable is always 0, whatever the direction term is.
- R5: In fixed-output mode the pin enable is always 1, and the drive is the polarity-adjusted sum.
- R6: In registered mode, the polarity-adjusted sum is captured on the rising edge of pin 1. The pin is driven from the register, the enable equals pin 11 (active high), and the feedback is the register value.
- R7: The global configuration output is 1 exactly when at least one cell is registered. While it is 1, the pin-1 and pin-11 feedbacks to the array read 0. While it is 0, they follow the pins.
- R8: If the preset term is high on a clock edge, and neither preload nor asynchronous clear is active, every register becomes 1.
- R9: The asynchronous clear term forces every register to 0 at once. It overrides preset and preload.
- R10: While rst_ni is low, every register reads 0.
- R11: If preload is enabled on a clock edge, each register loads its preload bit. Preload takes priority over preset and over normal capture.
- R12: For non-registered cells, the feedback is the pin value: the drive when the enable is 1, and the externally applied pin value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low power-up reset of all registers |
| pin1_i | input | 1 | Pin 1: register clock, or a plain input |
| pin11_i | input | 1 | Pin 11: shared enable of registered cells, or a plain input |
| ac1_i | input | 8 | First mode bit, one per cell |
| ac2_i | input | 8 | Second mode bit, one per cell |
| pol_i | input | 8 | Polarity bit, one per cell |
| sum_i | input | 8 | Sum-of-products value from the array, one per cell |
| dir_i | input | 8 | Direction term from the array, one per cell |
| sp_i | input | 1 | Global synchronous preset term |
| ar_i | input | 1 | Global asynchronous clear term |
| preload_en_i | input | 1 | Register preload strobe |
| preload_val_i | input | 8 | Values loaded by preload |
| pin_in_i | input | 8 | Value applied to each pin from outside |
| pin_o | output | 8 | Drive value of each pin |
| pin_oe_o | output | 8 | Output enable of each pin |
| fb_o | output | 8 | Feedback from each cell to the array |
| glb_cfg_o | output | 1 | Global clock/enable configuration bit |
| pin1_fb_o | output | 1 | Pin 1 seen as an array input |
| pin11_fb_o | output | 1 | Pin 11 seen as an array input |

## Verification
On every cycle, the assertions check the following. Fixed-input and fixed-output cells keep their enables pinned. The global bit agrees with the registered-cell mask. An active clear holds the registers at zero. Preset, preload and normal capture each land one edge later with the expected value. Only the bench scenarios can show whether every mode decodes correctly under both polarities, and whether feedback switches between register and pin. The bench also shows that preload beats preset, that clear beats preset, and that a mixed configuration enables only the registered cells from pin 11.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef enum logic [1:0] {
    M_BIDIR = 2'b00,
    M_FIN   = 2'b01,
    M_FOUT  = 2'b10,
    M_REG   = 2'b11
  } cell_mode_e;

  function automatic cell_mode_e decode_mode(input logic ac1, input logic ac2);
    return cell_mode_e'({ac1, ac2});
  endfunction
endpackage

// File: rtl/omc_glb_cfg.sv
module omc_glb_cfg #(
  parameter int N_CELLS = 8
) (
  input  logic [N_CELLS-1:0] is_reg_i,
  input  logic               pin1_i,
  input  logic               pin11_i,
  output logic               cfg_o,
  output logic               oe_shared_o,
  output logic               pin1_fb_o,
  output logic               pin11_fb_o
);
  assign cfg_o       = |is_reg_i;
  assign oe_shared_o = cfg_o & pin11_i;
  // dedicated pins only reach the array when not claimed as clock / enable
  assign pin1_fb_o   = ~cfg_o & pin1_i;
  assign pin11_fb_o  = ~cfg_o & pin11_i;
endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ar_i,
  input  logic sp_i,
  input  logic preload_en_i,
  input  logic preload_val_i,
  input  logic ac1_i,
  input  logic ac2_i,
  input  logic pol_i,
  input  logic sum_i,
  input  logic dir_i,
  input  logic oe_shared_i,
  input  logic pin_in_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic fb_o,
  output logic is_reg_o
);
  cell_mode_e mode;
  logic lvl, q, rst_n_eff, pin_val;

  assign mode      = decode_mode(ac1_i, ac2_i);
  assign is_reg_o  = (mode == M_REG);
  assign lvl       = pol_i ? sum_i : ~sum_i;
  assign rst_n_eff = rst_ni & ~ar_i;

  // clear > preload > preset > capture
  always_ff @(posedge clk_i or negedge rst_n_eff) begin
    if (!rst_n_eff)        q <= 1'b0;
    else if (preload_en_i) q <= preload_val_i;
    else if (sp_i)         q <= 1'b1;
    else if (is_reg_o)     q <= lvl;
  end

  always_comb begin
    unique case (mode)
      M_REG:   begin pin_o = q;   pin_oe_o = oe_shared_i; end
      M_BIDIR: begin pin_o = lvl; pin_oe_o = dir_i;       end
      M_FIN:   begin pin_o = lvl; pin_oe_o = 1'b0;        end
      default: begin pin_o = lvl; pin_oe_o = 1'b1;        end
    endcase
  end

  assign pin_val = pin_oe_o ? pin_o : pin_in_i;
  assign fb_o    = is_reg_o ? q : pin_val;

  always_comb begin
    if (rst_ni) begin
      p_fin_off_r4: assert (!(ac1_i == 1'b0 && ac2_i == 1'b1) || !pin_oe_o)
        else $error("fixed-input cell drives pin");
      p_fout_on_r5: assert (!(ac1_i == 1'b1 && ac2_i == 1'b0) || pin_oe_o)
        else $error("fixed-output cell not driving");
    end
  end

  p_clear_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ar_i) && ar_i) |-> !q);
  p_preload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_en_i && !ar_i) |=> (ar_i || q == $past(preload_val_i)));
  p_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_i && !preload_en_i && !ar_i) |=> (ar_i || q));
  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reg_o && !sp_i && !preload_en_i && !ar_i) |=>
      (ar_i || q == ($past(pol_i) ? $past(sum_i) : ~$past(sum_i))));
endmodule

// File: rtl/omc_bank.sv
module omc_bank #(
  parameter int N_CELLS = 8
) (
  input  logic               rst_ni,
  input  logic               pin1_i,
  input  logic               pin11_i,
  input  logic [N_CELLS-1:0] ac1_i,
  input  logic [N_CELLS-1:0] ac2_i,
  input  logic [N_CELLS-1:0] pol_i,
  input  logic [N_CELLS-1:0] sum_i,
  input  logic [N_CELLS-1:0] dir_i,
  input  logic               sp_i,
  input  logic               ar_i,
  input  logic               preload_en_i,
  input  logic [N_CELLS-1:0] preload_val_i,
  input  logic [N_CELLS-1:0] pin_in_i,
  output logic [N_CELLS-1:0] pin_o,
  output logic [N_CELLS-1:0] pin_oe_o,
  output logic [N_CELLS-1:0] fb_o,
  output logic               glb_cfg_o,
  output logic               pin1_fb_o,
  output logic               pin11_fb_o
);
  logic [N_CELLS-1:0] is_reg;
  logic               oe_shared;

  omc_glb_cfg #(.N_CELLS(N_CELLS)) u_glb (
    .is_reg_i   (is_reg),
    .pin1_i     (pin1_i),
    .pin11_i    (pin11_i),
    .cfg_o      (glb_cfg_o),
    .oe_shared_o(oe_shared),
    .pin1_fb_o  (pin1_fb_o),
    .pin11_fb_o (pin11_fb_o)
  );

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    omc_cell u_cell (
      .clk_i        (pin1_i),
      .rst_ni       (rst_ni),
      .ar_i         (ar_i),
      .sp_i         (sp_i),
      .preload_en_i (preload_en_i),
      .preload_val_i(preload_val_i[g]),
      .ac1_i        (ac1_i[g]),
      .ac2_i        (ac2_i[g]),
      .pol_i        (pol_i[g]),
      .sum_i        (sum_i[g]),
      .dir_i        (dir_i[g]),
      .oe_shared_i  (oe_shared),
      .pin_in_i     (pin_in_i[g]),
      .pin_o        (pin_o[g]),
      .pin_oe_o     (pin_oe_o[g]),
      .fb_o         (fb_o[g]),
      .is_reg_o     (is_reg[g])
    );
  end

  always_comb begin
    if (rst_ni) begin
      p_cfg_mask_r7: assert (glb_cfg_o == |(ac1_i & ac2_i))
        else $error("global config disagrees with registered cells");
    end
  end
endmodule

// File: tb/sim_omc_bank.sv
module sim_omc_bank;
  localparam int N = 8;

  logic         rst_ni, pin1_i, pin11_i, sp_i, ar_i, preload_en_i;
  logic [N-1:0] ac1_i, ac2_i, pol_i, sum_i, dir_i, preload_val_i, pin_in_i;
  logic [N-1:0] pin_o, pin_oe_o, fb_o;
  logic         glb_cfg_o, pin1_fb_o, pin11_fb_o;

  int n_chk = 0;
  int n_bad = 0;

  omc_bank #(.N_CELLS(N)) u0 (.*);

  initial pin1_i = 1'b0;
  always #2.5 pin1_i = ~pin1_i;

  // {ac1, ac2, pol, sum, dir, pin_in, exp_oe, exp_out, exp_fb}
  localparam logic [8:0] TBL [10] = '{
    9'b000010111, 9'b001011100, 9'b001100000, 9'b000101001,
    9'b011110000, 9'b010011001,
    9'b101100111, 9'b100101100, 9'b100010111, 9'b101001100
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic at_neg();
    @(negedge pin1_i);
  endtask

  task automatic after_pos();
    @(posedge pin1_i); #1;
  endtask

  initial begin
    rst_ni = 0; pin11_i = 0; sp_i = 0; ar_i = 0; preload_en_i = 0;
    ac1_i = '0; ac2_i = '0; pol_i = '0; sum_i = '0; dir_i = '0;
    preload_val_i = '0; pin_in_i = '0;
    repeat (2) at_neg(); #1;
    chk("R1 reset oe", pin_oe_o, '0);
    chk("R10 reset cfg", {7'b0, glb_cfg_o}, '0);
    at_neg(); rst_ni = 1;

    // combinational modes, all cells alike
    for (int i = 0; i < 10; i++) begin
      at_neg();
      {ac1_i, ac2_i, pol_i, sum_i, dir_i, pin_in_i} =
        {{N{TBL[i][8]}}, {N{TBL[i][7]}}, {N{TBL[i][6]}}, {N{TBL[i][5]}},
         {N{TBL[i][4]}}, {N{TBL[i][3]}}};
      pin11_i = i[0];
      #1;
      chk("R3/R4/R5 oe", pin_oe_o, {N{TBL[i][2]}});
      if (TBL[i][2]) chk("R2 drive", pin_o, {N{TBL[i][1]}});
      chk("R12 fb", fb_o, {N{TBL[i][0]}});
      chk("R7 cfg clear", {glb_cfg_o, pin1_fb_o, pin11_fb_o}, {5'b0, 1'b0, pin1_i, pin11_i});
    end

    // registered capture, pass polarity
    at_neg(); ac1_i = '1; ac2_i = '1; pol_i = '1; sum_i = 8'hA5; pin11_i = 1; pin_in_i = 8'h00;
    after_pos();
    chk("R6 capture", pin_o, 8'hA5);
    chk("R6 oe from pin11", pin_oe_o, 8'hFF);
    chk("R6 fb is reg", fb_o, 8'hA5);
    chk("R7 cfg set", {glb_cfg_o, pin1_fb_o, pin11_fb_o}, 8'b100);
    at_neg(); pol_i = '0;
    after_pos();
    chk("R2 invert reg", pin_o, 8'h5A);
    at_neg(); pin11_i = 0; #1;
    chk("R6 oe low", pin_oe_o, 8'h00);
    chk("R6 fb while disabled", fb_o, 8'h5A);

    // preset
    at_neg(); sp_i = 1;
    after_pos();
    chk("R8 preset", fb_o, 8'hFF);
    // preload beats preset
    at_neg(); preload_en_i = 1; preload_val_i = 8'h3C;
    after_pos();
    chk("R11 preload", fb_o, 8'h3C);
    at_neg(); preload_en_i = 0; sp_i = 0;
    // async clear mid-cycle, preset concurrent
    at_neg(); ar_i = 1; sp_i = 1; #1;
    chk("R9 async clear", fb_o, 8'h00);
    after_pos();
    chk("R9 clear beats preset", fb_o, 8'h00);
    at_neg(); ar_i = 0; sp_i = 0; sum_i = 8'h0F; pol_i = '1;
    after_pos();
    chk("R6 capture after clear", fb_o, 8'h0F);

    // power-up reset
    at_neg(); rst_ni = 0; #1;
    chk("R10 reset clears", fb_o, 8'h00);
    at_neg(); rst_ni = 1;

    // mixed: cell0 registered, rest fixed input
    at_neg(); ac1_i = 8'h01; ac2_i = 8'hFF; pin11_i = 1; pin_in_i = 8'hAA; sum_i = 8'h01;
    after_pos();
    chk("R7 mixed cfg", {7'b0, glb_cfg_o}, 8'h01);
    chk("R4 mixed oe", pin_oe_o, 8'h01);
    chk("R12 mixed fb", fb_o, 8'hAB);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule